// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block services a translation-buffer miss in hardware. Given a 32-bit virtual address, the kind of access (load or store) and the privilege of the requester, it fetches one directory word and then one page-table word over a single-word memory port. The directory is rooted at a base address supplied on an input. Each fetched word is checked for presence and for permission. The block marks the words it relied on as used, and as modified for stores. It then hands back either the final page-table word, for the translation buffer to store, or a fault record for the exception logic.

Only one walk runs at a time. A new request is taken only while the ready output is high. The memory port holds its request until the memory acknowledges it, so memory latency may be any number of cycles. Large-page directory words, caching of directory words and software fault recovery are handled elsewhere.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and right after it, `walk_ready` is 1 and `mem_req`, `resp_valid` and `fault_valid` are 0.
- R2: The directory word is read at `root_base + 4*vaddr[31:22]`. The page-table word is read at `{dir_word[31:12], 12'h000} + 4*vaddr[21:12]`.
- R3: A memory request keeps `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` steady until the cycle in which `mem_ack` is 1. Read data is taken in that same cycle. Each memory access therefore lasts until one cycle after the acknowledge.
- R4: A directory word with bit 0 (present) clear ends the walk with a fault and `fault_absent`=1. No page-table word is read and no word is written.
- R5: A page-table word with bit 0 clear ends the walk with a fault and `fault_absent`=1.
- R6: A store to a word whose bit 1 (writable) is clear, or a user access to a word whose bit 2 (user-allowed) is clear, is a protection fault with `fault_absent`=0. The directory is checked before the page table, and the access must be allowed at both levels.
- R7: A fault report carries the request's virtual address, its store flag and its user flag. It lasts exactly one cycle.
- R8: After a directory word passes its checks, bit 5 (accessed) is written into it, unless that bit is already set. This write completes before the page-table word is read.
- R9: After a page-table word passes its checks, the block writes back that word with bit 5 set, and with bit 6 (dirty) also set for a store. The write is issued only if this changes the word. All other bits are kept.
- R10: A successful walk raises `resp_valid` for exactly one cycle. `resp_entry` is the page-table word after the update of R9. No result is given before the write-back is acknowledged.
- R11: `walk_ready` is 0 from the cycle after a request is accepted until the cycle after the result or fault. At most one walk is in progress.
- R12: A word that fails its own checks is never written. A walk that faults issues no write, except the accessed-bit update of a directory word that passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| root_base | input | 32 | Physical address of the directory |
| walk_req | input | 1 | Start a walk (taken when `walk_ready` is 1) |
| walk_vaddr | input | 32 | Virtual address to resolve |
| walk_write | input | 1 | 1 for a store access |
| walk_user | input | 1 | 1 for a user-mode access |
| walk_ready | output | 1 | Idle and able to accept a walk |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 for a write access |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed this cycle |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| resp_valid | output | 1 | Walk succeeded (one cycle) |
| resp_entry | output | 32 | Updated page-table word |
| fault_valid | output | 1 | Walk faulted (one cycle) |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_absent | output | 1 | 1 = not present, 0 = protection |
| fault_write | output | 1 | Faulting access was a store |
| fault_user | output | 1 | Faulting access was user mode |

## Verification
The result of a walk is due a fixed number of cycles after the accepting edge. With L the memory model's wait cycles, each memory access costs L+2 cycles and each check state costs one cycle. The expected delay is therefore (accesses)*(L+2) + (checks), computed from the flags the bench placed in memory. The bench counts edges from acceptance and samples on the falling edge. It requires the result to appear exactly at that count, so both an early and a late answer are reported. L is rotated over 0, 1 and 2. One falling edge after each result, the bench reads back both memory words and the number of writes the model served.

// File: rtl/pw_pkg.sv
package pw_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_DIR_RD, S_DIR_CHK, S_DIR_WB,
    S_TBL_RD, S_TBL_CHK, S_TBL_WB, S_DONE, S_FAULT
  } walk_st_e;

  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_WRITABLE = 1;
  localparam int unsigned BIT_USER     = 2;
  localparam int unsigned BIT_ACCESSED = 5;
  localparam int unsigned BIT_DIRTY    = 6;
endpackage

// File: rtl/pw_addr_gen.sv
module pw_addr_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned OFS_W = 12
) (
  input  logic [AW-1:0]       root_base,
  input  logic [IDX_W-1:0]    dir_idx,
  input  logic [IDX_W-1:0]    tbl_idx,
  input  logic [AW-OFS_W-1:0] tbl_page,
  output logic [AW-1:0]       dir_addr,
  output logic [AW-1:0]       tbl_addr
);
  localparam int unsigned PAD_W = AW - IDX_W - 2;

  logic [AW-1:0] dir_ofs, tbl_ofs;

  // Entries are 4 bytes wide: index scaled by four.
  assign dir_ofs  = {{PAD_W{1'b0}}, dir_idx, 2'b00};
  assign tbl_ofs  = {{PAD_W{1'b0}}, tbl_idx, 2'b00};
  assign dir_addr = root_base + dir_ofs;
  assign tbl_addr = {tbl_page, {OFS_W{1'b0}}} + tbl_ofs;
endmodule

// File: rtl/pw_entry_check.sv
module pw_entry_check
  import pw_pkg::*;
#(
  parameter int unsigned EW      = 32,
  parameter bit          IS_LEAF = 1'b0
) (
  input  logic [EW-1:0] entry,
  input  logic          is_write,
  input  logic          is_user,
  output logic          present,
  output logic          perm_ok,
  output logic          need_wb,
  output logic [EW-1:0] wb_value
);
  logic [EW-1:0] set_mask;

  assign present = entry[BIT_PRESENT];
  assign perm_ok = (!is_write || entry[BIT_WRITABLE]) &&
                   (!is_user  || entry[BIT_USER]);

  generate
    if (IS_LEAF) begin : g_leaf
      always_comb begin
        set_mask = '0;
        set_mask[BIT_ACCESSED] = 1'b1;
        set_mask[BIT_DIRTY]    = is_write;
      end
    end else begin : g_dir
      always_comb begin
        set_mask = '0;
        set_mask[BIT_ACCESSED] = 1'b1;
      end
    end
  endgenerate

  assign wb_value = entry | set_mask;
  assign need_wb  = (wb_value != entry);
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [VA_W-1:0] root_base,
  input  logic            walk_req,
  input  logic [VA_W-1:0] walk_vaddr,
  input  logic            walk_write,
  input  logic            walk_user,
  output logic            walk_ready,
  output logic            mem_req,
  output logic            mem_we,
  output logic [VA_W-1:0] mem_addr,
  output logic [VA_W-1:0] mem_wdata,
  input  logic            mem_ack,
  input  logic [VA_W-1:0] mem_rdata,
  output logic            resp_valid,
  output logic [VA_W-1:0] resp_entry,
  output logic            fault_valid,
  output logic [VA_W-1:0] fault_vaddr,
  output logic            fault_absent,
  output logic            fault_write,
  output logic            fault_user
);
  localparam int unsigned OFS_W = VA_W - 2*IDX_W;

  walk_st_e state_q, state_d;

  logic [VA_W-1:0] va_q, pde_q, pte_q, pte_d;
  logic            wr_q, usr_q, absent_q, absent_d;
  logic            va_en, pde_en, pte_en, absent_en;

  logic [VA_W-1:0] dir_addr, tbl_addr, dir_wb_val, tbl_wb_val;
  logic            dir_present, dir_perm, dir_need_wb;
  logic            tbl_present, tbl_perm, tbl_need_wb;

  pw_addr_gen #(.AW(VA_W), .IDX_W(IDX_W), .OFS_W(OFS_W)) u_addr (
    .root_base (root_base),
    .dir_idx   (va_q[VA_W-1 -: IDX_W]),
    .tbl_idx   (va_q[OFS_W +: IDX_W]),
    .tbl_page  (pde_q[VA_W-1:OFS_W]),
    .dir_addr  (dir_addr),
    .tbl_addr  (tbl_addr)
  );

  pw_entry_check #(.EW(VA_W), .IS_LEAF(1'b0)) u_chk_dir (
    .entry    (pde_q),
    .is_write (wr_q),
    .is_user  (usr_q),
    .present  (dir_present),
    .perm_ok  (dir_perm),
    .need_wb  (dir_need_wb),
    .wb_value (dir_wb_val)
  );

  pw_entry_check #(.EW(VA_W), .IS_LEAF(1'b1)) u_chk_tbl (
    .entry    (pte_q),
    .is_write (wr_q),
    .is_user  (usr_q),
    .present  (tbl_present),
    .perm_ok  (tbl_perm),
    .need_wb  (tbl_need_wb),
    .wb_value (tbl_wb_val)
  );

  // Next-state and enable logic
  always_comb begin
    state_d   = state_q;
    va_en     = 1'b0;
    pde_en    = 1'b0;
    pte_en    = 1'b0;
    pte_d     = mem_rdata;
    absent_en = 1'b0;
    absent_d  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (walk_req) begin
          va_en   = 1'b1;
          state_d = S_DIR_RD;
        end
      end
      S_DIR_RD: begin
        if (mem_ack) begin
          pde_en  = 1'b1;
          state_d = S_DIR_CHK;
        end
      end
      S_DIR_CHK: begin
        absent_en = 1'b1;
        absent_d  = !dir_present;
        if (!dir_present || !dir_perm) state_d = S_FAULT;
        else if (dir_need_wb)          state_d = S_DIR_WB;
        else                           state_d = S_TBL_RD;
      end
      S_DIR_WB: begin
        if (mem_ack) state_d = S_TBL_RD;
      end
      S_TBL_RD: begin
        if (mem_ack) begin
          pte_en  = 1'b1;
          state_d = S_TBL_CHK;
        end
      end
      S_TBL_CHK: begin
        absent_en = 1'b1;
        absent_d  = !tbl_present;
        if (!tbl_present || !tbl_perm) state_d = S_FAULT;
        else if (tbl_need_wb)          state_d = S_TBL_WB;
        else                           state_d = S_DONE;
      end
      S_TBL_WB: begin
        if (mem_ack) begin
          pte_en  = 1'b1;
          pte_d   = tbl_wb_val;
          state_d = S_DONE;
        end
      end
      S_DONE:  state_d = S_IDLE;
      S_FAULT: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  // Datapath registers, no reset needed
  always_ff @(posedge clk) begin
    if (va_en) begin
      va_q  <= walk_vaddr;
      wr_q  <= walk_write;
      usr_q <= walk_user;
    end
    if (pde_en)    pde_q    <= mem_rdata;
    if (pte_en)    pte_q    <= pte_d;
    if (absent_en) absent_q <= absent_d;
  end

  // Outputs
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = tbl_addr;
    mem_wdata = tbl_wb_val;
    unique case (state_q)
      S_DIR_RD: begin mem_req = 1'b1; mem_addr = dir_addr; end
      S_DIR_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dir_addr;
        mem_wdata = dir_wb_val;
      end
      S_TBL_RD: mem_req = 1'b1;
      S_TBL_WB: begin mem_req = 1'b1; mem_we = 1'b1; end
      default: ;
    endcase
  end

  assign walk_ready   = (state_q == S_IDLE);
  assign resp_valid   = (state_q == S_DONE);
  assign resp_entry   = pte_q;
  assign fault_valid  = (state_q == S_FAULT);
  assign fault_vaddr  = va_q;
  assign fault_absent = absent_q;
  assign fault_write  = wr_q;
  assign fault_user   = usr_q;
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned VA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            walk_req,
  input logic            walk_ready,
  input logic            mem_req,
  input logic            mem_we,
  input logic [VA_W-1:0] mem_addr,
  input logic [VA_W-1:0] mem_wdata,
  input logic            mem_ack,
  input logic            resp_valid,
  input logic            resp_present,
  input logic            resp_accessed,
  input logic            fault_valid
);
  // R3: an unacknowledged request keeps its command steady
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_we) &&
                            $stable(mem_addr) && $stable(mem_wdata));

  // R11: acceptance makes the block busy
  assert_accept_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    walk_req && walk_ready |=> !walk_ready);

  // R11: memory traffic only while a walk is active
  assert_mem_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !walk_ready);

  // R10: success and fault are exclusive
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_valid && fault_valid));

  // R10: one-cycle result, then idle
  assert_resp_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid && walk_ready);

  // R7: one-cycle fault, then idle
  assert_fault_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> !fault_valid && walk_ready);

  // R9: a returned entry is present and marked used
  assert_resp_marked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> resp_present && resp_accessed);
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .walk_req      (walk_req),
  .walk_ready    (walk_ready),
  .mem_req       (mem_req),
  .mem_we        (mem_we),
  .mem_addr      (mem_addr),
  .mem_wdata     (mem_wdata),
  .mem_ack       (mem_ack),
  .resp_valid    (resp_valid),
  .resp_present  (resp_entry[0]),
  .resp_accessed (resp_entry[5]),
  .fault_valid   (fault_valid)
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          WATCHDOG   = 190000;
  localparam logic [31:0] ROOT       = 32'h0000_1000;
  localparam logic [19:0] TBL_PAGE   = 20'h00003;

  logic        clk, rst_n;
  logic [31:0] root_base, walk_vaddr, mem_addr, mem_wdata, mem_rdata;
  logic [31:0] resp_entry, fault_vaddr;
  logic        walk_req, walk_write, walk_user, walk_ready;
  logic        mem_req, mem_we, mem_ack;
  logic        resp_valid, fault_valid, fault_absent, fault_write, fault_user;

  logic [31:0] mem [4096];
  int          lat, cnt, wr_count;
  int          n_vec, n_bad;

  pt_walker u_dut (
    .clk(clk), .rst_n(rst_n), .root_base(root_base),
    .walk_req(walk_req), .walk_vaddr(walk_vaddr), .walk_write(walk_write),
    .walk_user(walk_user), .walk_ready(walk_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .resp_valid(resp_valid), .resp_entry(resp_entry),
    .fault_valid(fault_valid), .fault_vaddr(fault_vaddr),
    .fault_absent(fault_absent), .fault_write(fault_write),
    .fault_user(fault_user)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: acknowledges after lat wait cycles
  initial begin
    mem_ack = 1'b0; mem_rdata = '0; cnt = 0; wr_count = 0;
  end
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst_n && mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        mem_ack <= 1'b1;
        cnt     <= 0;
        if (mem_we) begin
          mem[mem_addr[13:2]] <= mem_wdata;
          wr_count            <= wr_count + 1;
        end else begin
          mem_rdata <= mem[mem_addr[13:2]];
        end
      end else begin
        cnt <= cnt + 1;
      end
    end
  end

  task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_bad++;
    $display("FAIL R11 watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    n_vec = 0; n_bad = 0; lat = 0;
    rst_n = 1'b0; walk_req = 1'b0; walk_vaddr = '0;
    walk_write = 1'b0; walk_user = 1'b0; root_base = ROOT;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_eq("R1 in reset", {28'h0, walk_ready, mem_req, resp_valid, fault_valid}, 32'h8);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check_eq("R1 after reset", {28'h0, walk_ready, mem_req, resp_valid, fault_valid}, 32'h8);

    for (int pf = 0; pf < 16; pf++) begin
      for (int tf = 0; tf < 32; tf++) begin
        for (int acc = 0; acc < 4; acc++) begin
          automatic int d   = (pf + tf) % 4;
          automatic int t   = (tf + acc) % 8;
          automatic bit wr  = acc[0];
          automatic bit us  = acc[1];
          automatic logic [31:0] pde, pte, pde_exp, pte_exp, va;
          automatic int  n_acc, n_chk, exp_wr, m, wr0;
          automatic bit  is_fault, absent;
          automatic string tag;

          pde = {TBL_PAGE, 12'h0} | 32'(pf[0]) | (32'(pf[1]) << 1) |
                (32'(pf[2]) << 2) | (32'(pf[3]) << 5) | (32'(tf % 8) << 9);
          pte = {20'h80000 + 20'(pf * 32 + tf), 12'h0} | 32'(tf[0]) |
                (32'(tf[1]) << 1) | (32'(tf[2]) << 2) | (32'(tf[3]) << 5) |
                (32'(tf[4]) << 6) | (32'(acc[0]) << 8);
          mem[12'h400 + 12'(d)] = pde;
          mem[12'hC00 + 12'(t)] = pte;
          lat = (pf + tf + acc) % 3;
          va  = {10'(d), 10'(t), 12'(pf * 37 + tf)};

          // Expected outcome
          pde_exp = pde; pte_exp = pte; exp_wr = 0;
          n_acc = 1; n_chk = 1; is_fault = 1'b1; absent = 1'b0;
          tag = "R10";
          if (!pde[0]) begin
            absent = 1'b1; tag = "R4";
          end else if ((wr && !pde[1]) || (us && !pde[2])) begin
            tag = "R6 dir";
          end else begin
            if (!pde[5]) begin
              pde_exp = pde | 32'h20; exp_wr++; n_acc++;
            end
            n_acc++; n_chk++;
            if (!pte[0]) begin
              absent = 1'b1; tag = "R5";
            end else if ((wr && !pte[1]) || (us && !pte[2])) begin
              tag = "R6 tbl";
            end else begin
              is_fault = 1'b0;
              pte_exp  = pte | 32'h20 | (wr ? 32'h40 : 32'h0);
              if (pte_exp != pte) begin exp_wr++; n_acc++; end
            end
          end

          @(negedge clk);
          wr0 = wr_count;
          walk_vaddr = va; walk_write = wr; walk_user = us; walk_req = 1'b1;
          @(posedge clk);
          @(negedge clk);
          walk_req = 1'b0;
          m = 0;
          while (!(resp_valid || fault_valid) && m < 100) begin
            @(posedge clk); @(negedge clk); m++;
          end
          // R3: each access lasts lat+2 cycles, each check one cycle
          check_eq({tag, " R3 latency"}, 32'(m), 32'(n_acc * (lat + 2) + n_chk));
          check_eq({tag, " kind"}, {30'h0, fault_valid, resp_valid},
                   is_fault ? 32'h2 : 32'h1);
          if (is_fault) begin
            check_eq({tag, " R7 vaddr"}, fault_vaddr, va);
            check_eq({tag, " R7 cause/write/user"},
                     {29'h0, fault_absent, fault_write, fault_user},
                     {29'h0, absent, wr, us});
          end else begin
            check_eq("R2 R9 R10 entry", resp_entry, pte_exp);
          end
          @(posedge clk); @(negedge clk);
          check_eq("R11 ready after result", {31'h0, walk_ready}, 32'h1);
          check_eq("R8 directory word", mem[12'h400 + 12'(d)], pde_exp);
          check_eq("R9 R12 table word", mem[12'hC00 + 12'(t)], pte_exp);
          check_eq("R8 R12 write count", 32'(wr_count - wr0), 32'(exp_wr));
        end
      end
    end
    finish_run();
  end
endmodule